// File: doc/BRIEF.md
# Home Lock Table for Queued Reader-Writer Locks

This block is the home-side directory for hardware reader-writer locks. Every lock address maps to exactly one such table, placed next to a memory controller. The table keeps one entry for each lock that is currently held. Each entry records the two ends of the lock's waiting queue. The head is the node that holds the lock token and the tail is the last node queued. Each end is kept as a (thread, controller, mode) tuple. An entry also carries a count of readers that were granted outside the queue, and a single reservation slot with its own timestamp.

Per-core lock controllers send three message kinds to the table: request, release and transfer notice. The table serves one message at a time, and each reply comes exactly two cycles after acceptance. A reply is one of the following:
- a grant;
- a retry;
- an acknowledge;
- a forward to the queue tail, carrying the head tuple;
- a forward to the head controller;
- a miss-to-memory indication.

Storage is set associative. When an allocation finds its set full, a victim is pushed out through a victim port, and a sticky overflow flag and an eviction counter record the spill. While the flag is set, any lookup that misses reports a memory miss instead of allocating.

Top module: `lrt_home`

## Requirements
- R1: A request (kind 0) that misses while the overflow flag is clear allocates an entry with head = tail = requestor and replies grant (code 0) with the head flag set, addressed to the requestor's controller.
- R2: A blocking request (nonblocking input low) that hits a held lock replies forward-to-tail (code 3) addressed to the old tail's controller, carrying the head tuple. The requestor becomes the new tail.
- R3: A release (kind 1) from the recorded head frees the entry and replies acknowledge (code 2) only when head and tail are the same node and no outside readers remain. Otherwise it replies retry (code 1).
- R4: A nonblocking read request on a lock whose head and tail are both read mode replies grant without the head flag and increments the outside-reader count. A nonblocking write request, or a nonblocking request on a lock with a writer at either end, replies retry.
- R5: A release from a node other than the head decrements the outside-reader count and acknowledges when the count is nonzero. Otherwise it replies forward-to-head (code 4) addressed to the head controller.
- R6: A nonblocking requestor answered with retry is recorded in the reservation slot if no live reservation exists. While the reservation is live, every other requestor gets retry, even after the lock is released. The holder's next served request consumes the reservation.
- R7: A reservation older than RESV_TIMEOUT cycles is ignored, and other requestors are served normally again.
- R8: A transfer notice (kind 2) replaces the head tuple with the sender and replies acknowledge addressed to the previous head's controller.
- R9: An allocation into a full set evicts the way named by a per-block rotating pointer. It pulses the victim port with that entry's address, sets the overflow flag and increments the eviction counter by one. The flag never clears.
- R10: While the overflow flag is set, any message that misses replies memory-miss (code 5) and allocates nothing.
- R11: Accepted messages are served one at a time. Ready drops for the cycle after acceptance, and the reply is valid for exactly one cycle, two cycles after acceptance. The reply echoes the message's address and thread.
- R12: A release or transfer notice that misses while the overflow flag is clear replies retry and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Message present |
| req_ready_o | output | 1 | Table idle, message taken this cycle |
| req_kind_i | input | 2 | 0 request, 1 release, 2 transfer notice |
| req_addr_i | input | ADDR_W | Lock address; low bits pick the set |
| req_tid_i | input | TID_W | Thread identifier |
| req_cid_i | input | CID_W | Sending controller |
| req_write_i | input | 1 | Write mode |
| req_nb_i | input | 1 | Sender entry is nonblocking |
| rsp_valid_o | output | 1 | Reply present (one cycle) |
| rsp_kind_o | output | 3 | 0 grant, 1 retry, 2 ack, 3 fwd tail, 4 fwd head, 5 memory miss |
| rsp_dest_o | output | CID_W | Controller the reply goes to |
| rsp_addr_o | output | ADDR_W | Echoed address |
| rsp_tid_o | output | TID_W | Echoed thread |
| rsp_head_o | output | 1 | Grant carries the head token |
| rsp_owner_tid_o | output | TID_W | Head thread (forwards, transfer ack) |
| rsp_owner_cid_o | output | CID_W | Head controller |
| rsp_owner_write_o | output | 1 | Head mode |
| victim_valid_o | output | 1 | Entry evicted to memory |
| victim_addr_o | output | ADDR_W | Address of evicted entry |
| ovf_flag_o | output | 1 | Entries exist in memory |
| ovf_cnt_o | output | CNT_W | Number of evictions |

## Verification
Every cycle, the assertions check the one-at-a-time service rhythm and the one-cycle reply pulse. They also check that the overflow flag is sticky, that every eviction raises the flag and steps the counter by exactly one, that a memory miss never evicts, and that a lookup never matches two ways. Only the bench scenarios can show the queue bookkeeping: forwards reaching the current tail, and head updates after transfer notices. The same holds for the retry cases on release, outside-reader counting, migrated-owner forwarding, the life and expiry of a reservation, and the victim chosen when a set fills.

// File: rtl/lrt_pkg.sv
package lrt_pkg;
  typedef enum logic [1:0] {MSG_REQ = 2'd0, MSG_REL = 2'd1, MSG_XFER = 2'd2} msg_e;
  typedef enum logic [2:0] {
    RSP_GRANT = 3'd0, RSP_RETRY = 3'd1, RSP_ACK = 3'd2,
    RSP_FWD_TAIL = 3'd3, RSP_FWD_HEAD = 3'd4, RSP_MISS = 3'd5
  } rsp_e;
  typedef enum logic [1:0] {SEL_HIT = 2'd0, SEL_FREE = 2'd1, SEL_VIC = 2'd2} sel_e;
endpackage

// File: rtl/lrt_store.sv
module lrt_store #(
  parameter int SETS  = 32,
  parameter int WAYS  = 16,
  parameter int ENT_W = 64,
  parameter int TAG_W = 8,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SET_W-1:0] rd_set_i,
  input  logic [TAG_W-1:0] rd_tag_i,
  input  logic [WAY_W-1:0] vic_way_i,
  output logic             hit_o,
  output logic [WAY_W-1:0] hit_way_o,
  output logic [ENT_W-1:0] hit_ent_o,
  output logic             free_vld_o,
  output logic [WAY_W-1:0] free_way_o,
  output logic [TAG_W-1:0] vic_tag_o,
  input  logic             wr_en_i,
  input  logic [SET_W-1:0] wr_set_i,
  input  logic [WAY_W-1:0] wr_way_i,
  input  logic [ENT_W-1:0] wr_ent_i
);
  logic [ENT_W-1:0] mem_q [SETS][WAYS];
  logic [WAYS-1:0]  hit_vec, free_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) mem_q[s][w] <= '0;
    end else if (wr_en_i) begin
      mem_q[wr_set_i][wr_way_i] <= wr_ent_i;
    end
  end

  // valid bit at the MSB, tag right below the held bit
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign hit_vec[w]  = mem_q[rd_set_i][w][ENT_W-1] &&
                         (mem_q[rd_set_i][w][ENT_W-3 -: TAG_W] == rd_tag_i);
    assign free_vec[w] = !mem_q[rd_set_i][w][ENT_W-1];
  end

  always_comb begin
    hit_way_o  = '0;
    free_way_o = '0;
    for (int w = WAYS-1; w >= 0; w--) begin
      if (hit_vec[w])  hit_way_o  = WAY_W'(w);
      if (free_vec[w]) free_way_o = WAY_W'(w);
    end
  end

  assign hit_o      = |hit_vec;
  assign free_vld_o = |free_vec;
  assign hit_ent_o  = mem_q[rd_set_i][hit_way_o];
  assign vic_tag_o  = mem_q[rd_set_i][vic_way_i][ENT_W-3 -: TAG_W];

  assert_unique_hit_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));
endmodule

// File: rtl/lrt_policy.sv
module lrt_policy import lrt_pkg::*; #(
  parameter int TAG_W        = 8,
  parameter int TID_W        = 4,
  parameter int CID_W        = 4,
  parameter int RC_W         = 8,
  parameter int TS_W         = 16,
  parameter int RESV_TIMEOUT = 1024,
  parameter int ENT_W        = 64
) (
  input  msg_e             kind_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic [TID_W-1:0] tid_i,
  input  logic [CID_W-1:0] cid_i,
  input  logic             wr_i,
  input  logic             nb_i,
  input  logic             hit_i,
  input  logic [ENT_W-1:0] hit_ent_i,
  input  logic             free_vld_i,
  input  logic             ovf_flag_i,
  input  logic [TS_W-1:0]  now_i,
  output rsp_e             rsp_kind_o,
  output logic [CID_W-1:0] rsp_dest_o,
  output logic             rsp_head_o,
  output logic [TID_W-1:0] own_tid_o,
  output logic [CID_W-1:0] own_cid_o,
  output logic             own_wr_o,
  output logic             wr_en_o,
  output sel_e             wr_sel_o,
  output logic [ENT_W-1:0] wr_ent_o,
  output logic             evict_o
);
  typedef struct packed {
    logic             valid;
    logic             held;
    logic [TAG_W-1:0] tag;
    logic [TID_W-1:0] h_tid;
    logic [CID_W-1:0] h_cid;
    logic             h_wr;
    logic [TID_W-1:0] t_tid;
    logic [CID_W-1:0] t_cid;
    logic             t_wr;
    logic [RC_W-1:0]  rd_cnt;
    logic             rs_vld;
    logic [TID_W-1:0] rs_tid;
    logic [CID_W-1:0] rs_cid;
    logic [TS_W-1:0]  rs_ts;
  } ent_t;

  ent_t e, n, f;
  logic [TS_W-1:0] elapsed;
  logic resv_live, is_holder, is_head, sole, all_rd;

  always_comb begin
    e         = ent_t'(hit_ent_i);
    elapsed   = now_i - e.rs_ts;
    resv_live = e.rs_vld && (int'(elapsed) < RESV_TIMEOUT);
    is_holder = (tid_i == e.rs_tid) && (cid_i == e.rs_cid);
    is_head   = (tid_i == e.h_tid) && (cid_i == e.h_cid);
    sole      = (e.h_tid == e.t_tid) && (e.h_cid == e.t_cid);
    all_rd    = !e.h_wr && !e.t_wr;

    f       = '0;
    f.valid = 1'b1;
    f.held  = 1'b1;
    f.tag   = tag_i;
    f.h_tid = tid_i; f.h_cid = cid_i; f.h_wr = wr_i;
    f.t_tid = tid_i; f.t_cid = cid_i; f.t_wr = wr_i;

    n          = e;
    rsp_kind_o = RSP_RETRY;
    rsp_dest_o = cid_i;
    rsp_head_o = 1'b0;
    own_tid_o  = e.h_tid;
    own_cid_o  = e.h_cid;
    own_wr_o   = e.h_wr;
    wr_en_o    = 1'b0;
    wr_sel_o   = SEL_HIT;
    evict_o    = 1'b0;

    if (!hit_i) begin
      if (ovf_flag_i) rsp_kind_o = RSP_MISS;
      else if (kind_i == MSG_REQ) begin
        rsp_kind_o = RSP_GRANT;
        rsp_head_o = 1'b1;
        n          = f;
        wr_en_o    = 1'b1;
        wr_sel_o   = free_vld_i ? SEL_FREE : SEL_VIC;
        evict_o    = !free_vld_i;
      end
    end else begin
      unique case (kind_i)
        MSG_REQ: begin
          if (resv_live && !is_holder) begin
            rsp_kind_o = RSP_RETRY;
          end else if (!e.held) begin
            rsp_kind_o = RSP_GRANT;
            rsp_head_o = 1'b1;
            n          = f;
            wr_en_o    = 1'b1;
          end else if (nb_i) begin
            if (!wr_i && all_rd && !(&e.rd_cnt)) begin
              rsp_kind_o = RSP_GRANT;
              n.rd_cnt   = e.rd_cnt + 1'b1;
              n.rs_vld   = 1'b0;
              wr_en_o    = 1'b1;
            end else if (!resv_live) begin
              n.rs_vld  = 1'b1;
              n.rs_tid  = tid_i;
              n.rs_cid  = cid_i;
              n.rs_ts   = now_i;
              wr_en_o   = 1'b1;
            end
          end else begin
            rsp_kind_o = RSP_FWD_TAIL;
            rsp_dest_o = e.t_cid;
            n.t_tid    = tid_i;
            n.t_cid    = cid_i;
            n.t_wr     = wr_i;
            n.rs_vld   = 1'b0;
            wr_en_o    = 1'b1;
          end
        end
        MSG_REL: begin
          if (!e.held) begin
            rsp_kind_o = RSP_RETRY;
          end else if (is_head) begin
            if (sole && e.rd_cnt == '0) begin
              rsp_kind_o = RSP_ACK;
              // a live reservation keeps the entry, lock free, for its holder
              if (resv_live) n.held  = 1'b0;
              else           n.valid = 1'b0;
              wr_en_o = 1'b1;
            end
          end else if (e.rd_cnt != '0) begin
            rsp_kind_o = RSP_ACK;
            n.rd_cnt   = e.rd_cnt - 1'b1;
            wr_en_o    = 1'b1;
          end else begin
            rsp_kind_o = RSP_FWD_HEAD;
            rsp_dest_o = e.h_cid;
          end
        end
        MSG_XFER: begin
          if (e.held) begin
            rsp_kind_o = RSP_ACK;
            rsp_dest_o = e.h_cid;
            n.h_tid    = tid_i;
            n.h_cid    = cid_i;
            n.h_wr     = wr_i;
            wr_en_o    = 1'b1;
          end
        end
        default: rsp_kind_o = RSP_RETRY;
      endcase
    end
    wr_ent_o = n;
  end
endmodule

// File: rtl/lrt_home.sv
module lrt_home import lrt_pkg::*; #(
  parameter int ADDR_W       = 32,
  parameter int TID_W        = 8,
  parameter int CID_W        = 6,
  parameter int ENTRIES      = 512,
  parameter int WAYS         = 16,
  parameter int RC_W         = 8,
  parameter int TS_W         = 16,
  parameter int RESV_TIMEOUT = 1024,
  parameter int CNT_W        = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_kind_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [TID_W-1:0]  req_tid_i,
  input  logic [CID_W-1:0]  req_cid_i,
  input  logic              req_write_i,
  input  logic              req_nb_i,
  output logic              rsp_valid_o,
  output logic [2:0]        rsp_kind_o,
  output logic [CID_W-1:0]  rsp_dest_o,
  output logic [ADDR_W-1:0] rsp_addr_o,
  output logic [TID_W-1:0]  rsp_tid_o,
  output logic              rsp_head_o,
  output logic [TID_W-1:0]  rsp_owner_tid_o,
  output logic [CID_W-1:0]  rsp_owner_cid_o,
  output logic              rsp_owner_write_o,
  output logic              victim_valid_o,
  output logic [ADDR_W-1:0] victim_addr_o,
  output logic              ovf_flag_o,
  output logic [CNT_W-1:0]  ovf_cnt_o
);
  localparam int SETS  = ENTRIES / WAYS;
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = ADDR_W - SET_W;
  localparam int ENT_W = 2 + TAG_W + 2 * (TID_W + CID_W + 1) + RC_W + 1 + TID_W + CID_W + TS_W;

  logic              busy_q;
  msg_e              kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [TID_W-1:0]  tid_q;
  logic [CID_W-1:0]  cid_q;
  logic              wr_q, nb_q;
  logic [TS_W-1:0]   now_q;
  logic [WAY_W-1:0]  rr_q;

  logic              hit, free_vld, wr_en, evict, p_head, own_wr;
  logic [WAY_W-1:0]  hit_way, free_way, wr_way;
  logic [ENT_W-1:0]  hit_ent, wr_ent;
  logic [TAG_W-1:0]  vic_tag;
  rsp_e              p_kind;
  sel_e              wr_sel;
  logic [CID_W-1:0]  p_dest, own_cid;
  logic [TID_W-1:0]  own_tid;
  logic [SET_W-1:0]  set_idx;
  logic [TAG_W-1:0]  tag;
  logic              do_wr;

  assign set_idx     = addr_q[SET_W-1:0];
  assign tag         = addr_q[ADDR_W-1:SET_W];
  assign req_ready_o = !busy_q;
  assign do_wr       = busy_q && wr_en;

  always_comb begin
    unique case (wr_sel)
      SEL_FREE: wr_way = free_way;
      SEL_VIC:  wr_way = rr_q;
      default:  wr_way = hit_way;
    endcase
  end

  lrt_store #(.SETS(SETS), .WAYS(WAYS), .ENT_W(ENT_W), .TAG_W(TAG_W)) i_store (
    .clk_i, .rst_ni,
    .rd_set_i(set_idx), .rd_tag_i(tag), .vic_way_i(rr_q),
    .hit_o(hit), .hit_way_o(hit_way), .hit_ent_o(hit_ent),
    .free_vld_o(free_vld), .free_way_o(free_way), .vic_tag_o(vic_tag),
    .wr_en_i(do_wr), .wr_set_i(set_idx), .wr_way_i(wr_way), .wr_ent_i(wr_ent)
  );

  lrt_policy #(.TAG_W(TAG_W), .TID_W(TID_W), .CID_W(CID_W), .RC_W(RC_W), .TS_W(TS_W),
               .RESV_TIMEOUT(RESV_TIMEOUT), .ENT_W(ENT_W)) i_policy (
    .kind_i(kind_q), .tag_i(tag), .tid_i(tid_q), .cid_i(cid_q), .wr_i(wr_q), .nb_i(nb_q),
    .hit_i(hit), .hit_ent_i(hit_ent), .free_vld_i(free_vld), .ovf_flag_i(ovf_flag_o),
    .now_i(now_q), .rsp_kind_o(p_kind), .rsp_dest_o(p_dest), .rsp_head_o(p_head),
    .own_tid_o(own_tid), .own_cid_o(own_cid), .own_wr_o(own_wr),
    .wr_en_o(wr_en), .wr_sel_o(wr_sel), .wr_ent_o(wr_ent), .evict_o(evict)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; kind_q <= MSG_REQ; addr_q <= '0; tid_q <= '0; cid_q <= '0;
      wr_q <= 1'b0; nb_q <= 1'b0; now_q <= '0; rr_q <= '0;
      rsp_valid_o <= 1'b0; rsp_kind_o <= '0; rsp_dest_o <= '0; rsp_addr_o <= '0;
      rsp_tid_o <= '0; rsp_head_o <= 1'b0; rsp_owner_tid_o <= '0; rsp_owner_cid_o <= '0;
      rsp_owner_write_o <= 1'b0; victim_valid_o <= 1'b0; victim_addr_o <= '0;
      ovf_flag_o <= 1'b0; ovf_cnt_o <= '0;
    end else begin
      now_q          <= now_q + 1'b1;
      rsp_valid_o    <= busy_q;
      victim_valid_o <= busy_q && evict;
      if (!busy_q && req_valid_i) begin
        busy_q <= 1'b1;
        kind_q <= msg_e'(req_kind_i);
        addr_q <= req_addr_i;
        tid_q  <= req_tid_i;
        cid_q  <= req_cid_i;
        wr_q   <= req_write_i;
        nb_q   <= req_nb_i;
      end
      if (busy_q) begin
        busy_q            <= 1'b0;
        rsp_kind_o        <= p_kind;
        rsp_dest_o        <= p_dest;
        rsp_addr_o        <= addr_q;
        rsp_tid_o         <= tid_q;
        rsp_head_o        <= p_head;
        rsp_owner_tid_o   <= own_tid;
        rsp_owner_cid_o   <= own_cid;
        rsp_owner_write_o <= own_wr;
        if (evict) begin
          victim_addr_o <= {vic_tag, set_idx};
          ovf_flag_o    <= 1'b1;
          ovf_cnt_o     <= ovf_cnt_o + 1'b1;
          rr_q          <= (int'(rr_q) == WAYS - 1) ? '0 : rr_q + 1'b1;
        end
      end
    end
  end

  assert_busy_after_accept_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);
  assert_reply_follows_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ready_o |=> rsp_valid_o);
  assert_reply_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  assert_flag_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_flag_o |=> ovf_flag_o);
  assert_evict_counts_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    victim_valid_o |-> (ovf_flag_o && ovf_cnt_o == CNT_W'($past(ovf_cnt_o) + 1'b1)));
  assert_miss_no_alloc_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_kind_o == 3'd5) |-> !victim_valid_o);
endmodule

// File: tb/test_lrt_home.sv
module test_lrt_home;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 8, TID_W = 4, CID_W = 3, CNT_W = 16, TMO = 32;
  localparam int K_REQ = 0, K_REL = 1, K_XFER = 2;
  localparam int GRANT = 0, RETRY = 1, ACK = 2, FWDT = 3, FWDH = 4, MISS = 5;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_valid_i = 0, req_write_i = 0, req_nb_i = 0;
  logic [1:0] req_kind_i = '0;
  logic [ADDR_W-1:0] req_addr_i = '0;
  logic [TID_W-1:0] req_tid_i = '0;
  logic [CID_W-1:0] req_cid_i = '0;
  logic req_ready_o, rsp_valid_o, rsp_head_o, rsp_owner_write_o, victim_valid_o, ovf_flag_o;
  logic [2:0] rsp_kind_o;
  logic [CID_W-1:0] rsp_dest_o, rsp_owner_cid_o;
  logic [ADDR_W-1:0] rsp_addr_o, victim_addr_o;
  logic [TID_W-1:0] rsp_tid_o, rsp_owner_tid_o;
  logic [CNT_W-1:0] ovf_cnt_o;

  int n_checks = 0, n_fail = 0;
  int r_own_tid, r_vic, r_vaddr;

  always #(CLK_PERIOD/2) clk = ~clk;

  lrt_home #(.ADDR_W(ADDR_W), .TID_W(TID_W), .CID_W(CID_W), .ENTRIES(8), .WAYS(2),
             .RC_W(3), .TS_W(8), .RESV_TIMEOUT(TMO), .CNT_W(CNT_W)) i_lrt_home (.*, .clk_i(clk));

  task automatic chk(input string rq, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic op(input int k, input int addr, input int tid, input int cid, input bit wr,
                    input bit nb, input int ek, input int edest, input int ehead, input string rq);
    @(negedge clk);
    req_valid_i = 1; req_kind_i = 2'(k); req_addr_i = ADDR_W'(addr);
    req_tid_i = TID_W'(tid); req_cid_i = CID_W'(cid); req_write_i = wr; req_nb_i = nb;
    @(posedge clk); #1;
    req_valid_i = 0;
    chk("R11 ready low while busy", int'(req_ready_o), 0);
    @(posedge clk); #1;
    chk("R11 reply valid", int'(rsp_valid_o), 1);
    chk("R11 addr echo", int'(rsp_addr_o), addr);
    chk("R11 tid echo", int'(rsp_tid_o), tid);
    chk({rq, " kind"}, int'(rsp_kind_o), ek);
    chk({rq, " dest"}, int'(rsp_dest_o), edest);
    if (ek == GRANT) chk({rq, " head flag"}, int'(rsp_head_o), ehead);
    r_own_tid = int'(rsp_owner_tid_o);
    r_vic = int'(victim_valid_o);
    r_vaddr = int'(victim_addr_o);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1;
    #1;
    chk("R11 reset ready", int'(req_ready_o), 1);
    chk("R11 reset rsp", int'(rsp_valid_o), 0);
    chk("R9 reset flag", int'(ovf_flag_o), 0);
    chk("R9 reset count", int'(ovf_cnt_o), 0);

    // R1 sweep: fill every set, way w gets tag w+1, mode write = w
    for (int s = 0; s < 4; s++)
      for (int w = 0; w < 2; w++) begin
        op(K_REQ, ((w + 1) << 2) | s, s, w, bit'(w), 0, GRANT, w, 1, "R1 alloc");
        chk("R1 no victim while free", r_vic, 0);
      end
    chk("R9 flag clear after fill", int'(ovf_flag_o), 0);

    // queue on addr 8: head (0,1) write
    op(K_REQ, 8, 9, 5, 1, 0, FWDT, 1, 0, "R2 fwd to tail");
    chk("R2 head tuple", r_own_tid, 0);
    op(K_REQ, 8, 10, 6, 1, 0, FWDT, 5, 0, "R2 tail updated");
    chk("R2 head unchanged", r_own_tid, 0);
    op(K_REL, 8, 0, 1, 1, 0, RETRY, 1, 0, "R3 head with queue");
    op(K_XFER, 8, 9, 5, 1, 0, ACK, 1, 0, "R8 ack old head");
    op(K_REL, 8, 9, 5, 1, 0, RETRY, 5, 0, "R3 new head with queue");
    op(K_REQ, 8, 11, 2, 1, 0, FWDT, 6, 0, "R2 fwd after xfer");
    chk("R8 head replaced", r_own_tid, 9);
    op(K_XFER, 8, 10, 6, 1, 0, ACK, 5, 0, "R8 second xfer");
    op(K_XFER, 8, 11, 2, 1, 0, ACK, 6, 0, "R8 third xfer");
    op(K_REL, 8, 11, 2, 1, 0, ACK, 2, 0, "R3 sole release");
    op(K_REQ, 8, 4, 3, 1, 0, GRANT, 3, 1, "R1 realloc after free");
    chk("R9 no eviction on freed way", r_vic, 0);

    // outside readers on addr 6: head (2,0) read
    op(K_REQ, 6, 11, 3, 0, 1, GRANT, 3, 0, "R4 outside read grant");
    op(K_REQ, 6, 12, 2, 0, 1, GRANT, 2, 0, "R4 second outside read");
    op(K_REL, 6, 2, 0, 0, 0, RETRY, 0, 0, "R3 readers outstanding");
    op(K_REL, 6, 11, 3, 0, 0, ACK, 3, 0, "R5 reader decrement");
    op(K_REL, 6, 12, 2, 0, 0, ACK, 2, 0, "R5 last reader");
    op(K_REL, 6, 14, 6, 0, 0, FWDH, 0, 0, "R5 migrated owner");
    chk("R5 head tuple", r_own_tid, 2);
    op(K_REL, 6, 2, 0, 0, 0, ACK, 0, 0, "R3 head after readers");

    // reservation on addr 9: head (1,1) write
    op(K_REQ, 9, 12, 7, 0, 1, RETRY, 7, 0, "R4 nb on write lock");
    op(K_REQ, 9, 13, 4, 1, 0, RETRY, 4, 0, "R6 others blocked");
    op(K_REQ, 9, 12, 7, 0, 1, RETRY, 7, 0, "R6 holder waits");
    op(K_REL, 9, 1, 1, 1, 0, ACK, 1, 0, "R3 release reserved lock");
    op(K_REQ, 9, 13, 4, 1, 0, RETRY, 4, 0, "R6 free but reserved");
    op(K_REQ, 9, 12, 7, 0, 1, GRANT, 7, 1, "R6 holder granted");
    op(K_REQ, 9, 13, 4, 1, 0, FWDT, 7, 0, "R6 reservation consumed");
    chk("R6 holder is head", r_own_tid, 12);

    // reservation timeout on addr 7: head (3,0) read
    op(K_REQ, 7, 13, 4, 1, 1, RETRY, 4, 0, "R4 nb write on read lock");
    op(K_REQ, 7, 5, 5, 1, 0, RETRY, 5, 0, "R6 before timeout");
    repeat (TMO + 8) @(posedge clk);
    op(K_REQ, 7, 5, 5, 1, 0, FWDT, 0, 0, "R7 after timeout");

    // misses with flag clear
    op(K_REL, 29, 1, 1, 1, 0, RETRY, 1, 0, "R12 release miss");
    op(K_XFER, 29, 1, 1, 1, 0, RETRY, 1, 0, "R12 xfer miss");
    chk("R12 no victim", r_vic, 0);

    // eviction: set 0 full (addr 4 in way 0, addr 8 in way 1)
    op(K_REQ, 12, 6, 6, 1, 0, GRANT, 6, 1, "R9 alloc into full set");
    chk("R9 victim pulse", r_vic, 1);
    chk("R9 victim address", r_vaddr, 4);
    chk("R9 flag set", int'(ovf_flag_o), 1);
    chk("R9 count", int'(ovf_cnt_o), 1);
    op(K_REQ, 4, 7, 1, 1, 0, MISS, 1, 0, "R10 evicted addr");
    chk("R10 no victim", r_vic, 0);
    op(K_REQ, 23, 7, 1, 1, 0, MISS, 1, 0, "R10 new addr");
    op(K_REL, 4, 0, 0, 0, 0, MISS, 0, 0, "R10 release miss");
    chk("R10 count unchanged", int'(ovf_cnt_o), 1);
    op(K_REQ, 12, 8, 2, 1, 0, FWDT, 6, 0, "R2 hit after overflow");
    op(K_REQ, 4, 7, 1, 1, 0, MISS, 1, 0, "R10 still no alloc");
    @(posedge clk); #1;
    chk("R11 reply one cycle", int'(rsp_valid_o), 0);
    chk("R9 flag sticky", int'(ovf_flag_o), 1);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule